// File: doc/BRIEF.md
# Disk DMA Channel Status and Table Pointer Registers

This block is the register slice for one channel of a bus-master disk DMA engine. A chip holds two copies, one primary and one secondary, and a parameter sets which one each copy is. Each copy holds an 8-bit status byte and a 32-bit pointer to the base of the descriptor table. Both are reached through a byte-addressed register port with byte enables. The port decodes a 4-bit byte offset, and a 32-bit data word carries each aligned group of four bytes.

The status byte gathers hardware events. A rising edge on the drive interrupt line sets the interrupt flag, and so does a masked interrupt, because masking happens outside this block. An abort on the system bus sets the error flag. Software clears either flag by writing a one to it. The active flag follows the DMA engine's start level and its end-of-table completion pulse. Two flags that software can write record whether each drive can do DMA, and the hardware never reads them. The pointer is offered on a plain output to the descriptor fetch logic. Its two low bits are held at zero, so the table always starts on a 4-byte boundary.

Top module: `rdma_chan_regs`

## Requirements
- R1: After reset the status byte reads 00h, the pointer reads 00000000h and `desc_base` is 00000000h.
- R2: The port uses `reg_addr[3:2]` to pick a word, and byte offset k sits in data lane k mod 4 (bits 8k+7:8k). The primary copy (CHANNEL=0) places the status byte at offset 2h and the pointer at offsets 4h–7h. The secondary copy (CHANNEL=1) places them at Ah and Ch–Fh. Every other byte reads 0 and ignores writes.
- R3: Status bits 6 and 5 are read/write and are kept until they are written again. Status bits 7, 4 and 3 always read 0.
- R4: `drv_irq` passes through a two-stage synchronizer before edge detection. When it rises before clock edge n, status bit 2 reads 1 after edge n+2. The flag sets whatever mask state applies elsewhere.
- R5: Writing 1 to status bit 2 clears it. While `drv_irq` stays high the bit stays 0, and it sets again only on the next rising edge.
- R6: A one-cycle `bus_abort` pulse sets status bit 1, which reads 1 after the next edge. Writing 1 to bit 1 clears it.
- R7: Writing 0 to bit 2 or bit 1 leaves that bit unchanged. When a hardware set and a software clear of the same bit fall in one cycle, the bit ends up 1.
- R8: Status bit 0 is read-only. A rising `start_lvl` sets it after that edge. An `eot_done` pulse clears it, and so does a falling `start_lvl`. If a rise and `eot_done` coincide, the bit ends up 1.
- R9: Each byte of the pointer updates only when its byte enable is set. Pointer bits 1:0 always read 0. `desc_base` always equals the pointer value.
- R10: A status write takes effect only when `reg_be[2]` is set. With lane 2 disabled, all status bits are left as they were.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, synchronous to clk |
| reg_addr | input | 4 | Byte offset of the access; bits 3:2 pick the word |
| reg_wr | input | 1 | Write strobe for one cycle |
| reg_be | input | 4 | Byte-lane write enables |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for the word at `reg_addr`, combinational |
| drv_irq | input | 1 | Drive interrupt line, asynchronous |
| start_lvl | input | 1 | Start level from the DMA command logic |
| eot_done | input | 1 | Pulse marking the last transfer of the final region |
| bus_abort | input | 1 | Pulse marking a target or master abort |
| desc_base | output | 32 | Descriptor table base address |

## Verification
Any fault in the status byte shows up at `reg_rdata` on the next read, and the effect of an event is visible one edge after the event. The interrupt flag is the exception: it takes two extra edges because of its synchronizer. The bench checks the interrupt flag one edge early and again when it is due, so a missing or extra stage appears as a miscompare. If the edge detector were replaced by a level detector, the interrupt flag would come back at once after being cleared while the line is high, and the next read would show it. A pointer fault appears on `desc_base` in the same cycle as the bad write, and on the next read of the pointer word.

// File: rtl/rdma_pkg.sv
package rdma_pkg;

  localparam int REG_DW   = 32;
  localparam int REG_AW   = 4;
  localparam int LANES    = REG_DW / 8;
  localparam int STAT_LANE = 2;

  localparam int B_ACT  = 0;
  localparam int B_ERR  = 1;
  localparam int B_IRQ  = 2;
  localparam int B_CAP0 = 5;
  localparam int B_CAP1 = 6;

  typedef logic [1:0] word_sel_t;

  function automatic word_sel_t stat_word(input int chan);
    return (chan != 0) ? 2'd2 : 2'd0;
  endfunction

  function automatic word_sel_t ptr_word(input int chan);
    return (chan != 0) ? 2'd3 : 2'd1;
  endfunction

endpackage

// File: rtl/rdma_irq_edge.sv
module rdma_irq_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_in,
  output logic rise
);

  logic [STAGES-1:0] sync_q;
  logic              last_q;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_sync
      if (i == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (!rst_n) sync_q[0] <= 1'b0;
          else        sync_q[0] <= line_in;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (!rst_n) sync_q[i] <= 1'b0;
          else        sync_q[i] <= sync_q[i-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) last_q <= 1'b0;
    else        last_q <= sync_q[STAGES-1];
  end

  assign rise = sync_q[STAGES-1] & ~last_q;

endmodule

// File: rtl/rdma_stat_reg.sv
module rdma_stat_reg
  import rdma_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [7:0] wbyte,
  input  logic       irq_rise,
  input  logic       abort,
  input  logic       start_rise,
  input  logic       start_fall,
  input  logic       eot,
  output logic [7:0] stat
);

  logic       act_q, err_q, irq_q;
  logic [1:0] cap_q;
  logic       act_d, err_d, irq_d;
  logic [1:0] cap_d;
  logic       unused_wbits;

  assign unused_wbits = ^{wbyte[7], wbyte[4:3], wbyte[0]};

  always_comb begin
    irq_d = irq_q;
    if (wr_en && wbyte[B_IRQ]) irq_d = 1'b0;
    if (irq_rise)              irq_d = 1'b1;

    err_d = err_q;
    if (wr_en && wbyte[B_ERR]) err_d = 1'b0;
    if (abort)                 err_d = 1'b1;

    act_d = act_q;
    if (eot || start_fall) act_d = 1'b0;
    if (start_rise)        act_d = 1'b1;

    cap_d = wr_en ? wbyte[B_CAP1:B_CAP0] : cap_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act_q <= 1'b0;
      err_q <= 1'b0;
      irq_q <= 1'b0;
      cap_q <= 2'b00;
    end else begin
      act_q <= act_d;
      err_q <= err_d;
      irq_q <= irq_d;
      cap_q <= cap_d;
    end
  end

  assign stat = {1'b0, cap_q, 2'b00, irq_q, err_q, act_q};

endmodule

// File: rtl/rdma_ptr_reg.sv
module rdma_ptr_reg
  import rdma_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [LANES-1:0]  be,
  input  logic [REG_DW-1:0] wdata,
  output logic [REG_DW-1:0] ptr
);

  logic [REG_DW-1:0] ptr_q;
  logic              unused_low;

  assign unused_low = ^wdata[1:0];

  generate
    for (genvar b = 0; b < LANES; b++) begin : g_lane
      if (b == 0) begin : g_low
        always_ff @(posedge clk) begin
          if (!rst_n)                 ptr_q[7:0] <= 8'h00;
          else if (wr_en && be[0])    ptr_q[7:0] <= {wdata[7:2], 2'b00};
        end
      end else begin : g_hi
        always_ff @(posedge clk) begin
          if (!rst_n)              ptr_q[8*b +: 8] <= 8'h00;
          else if (wr_en && be[b]) ptr_q[8*b +: 8] <= wdata[8*b +: 8];
        end
      end
    end
  endgenerate

  assign ptr = {ptr_q[REG_DW-1:2], 2'b00};

endmodule

// File: rtl/rdma_chan_regs.sv
module rdma_chan_regs
  import rdma_pkg::*;
#(
  parameter int CHANNEL   = 0,
  parameter int IRQ_SYNC  = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [3:0]  reg_addr,
  input  logic        reg_wr,
  input  logic [3:0]  reg_be,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  input  logic        drv_irq,
  input  logic        start_lvl,
  input  logic        eot_done,
  input  logic        bus_abort,
  output logic [31:0] desc_base
);

  localparam word_sel_t STAT_W = stat_word(CHANNEL);
  localparam word_sel_t PTR_W  = ptr_word(CHANNEL);

  word_sel_t   wsel;
  logic        stat_hit, ptr_hit;
  logic        irq_rise;
  logic        start_q;
  logic [7:0]  status_q;
  logic [31:0] ptr_val;
  logic        unused_addr;

  assign wsel        = reg_addr[3:2];
  assign unused_addr = ^reg_addr[1:0];
  assign stat_hit    = (wsel == STAT_W);
  assign ptr_hit     = (wsel == PTR_W);

  rdma_irq_edge #(.STAGES(IRQ_SYNC)) u_irq (
    .clk     (clk),
    .rst_n   (rst_n),
    .line_in (drv_irq),
    .rise    (irq_rise)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) start_q <= 1'b0;
    else        start_q <= start_lvl;
  end

  rdma_stat_reg u_stat (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (reg_wr && stat_hit && reg_be[STAT_LANE]),
    .wbyte      (reg_wdata[8*STAT_LANE +: 8]),
    .irq_rise   (irq_rise),
    .abort      (bus_abort),
    .start_rise (start_lvl & ~start_q),
    .start_fall (~start_lvl & start_q),
    .eot        (eot_done),
    .stat       (status_q)
  );

  rdma_ptr_reg u_ptr (
    .clk   (clk),
    .rst_n (rst_n),
    .wr_en (reg_wr && ptr_hit),
    .be    (reg_be),
    .wdata (reg_wdata),
    .ptr   (ptr_val)
  );

  always_comb begin
    reg_rdata = '0;
    if (stat_hit)     reg_rdata[8*STAT_LANE +: 8] = status_q;
    else if (ptr_hit) reg_rdata = ptr_val;
  end

  assign desc_base = ptr_val;

endmodule

// File: rtl/rdma_chan_regs_chk.sv
module rdma_chan_regs_chk
  import rdma_pkg::*;
#(
  parameter int CHANNEL = 0
) (
  input logic        clk,
  input logic        rst_n,
  input logic [3:0]  reg_addr,
  input logic        reg_wr,
  input logic [3:0]  reg_be,
  input logic [31:0] reg_rdata,
  input logic        start_lvl,
  input logic        eot_done,
  input logic        bus_abort,
  input logic [31:0] desc_base,
  input logic [7:0]  stat
);

  logic stat_wr;
  assign stat_wr = reg_wr && (reg_addr[3:2] == stat_word(CHANNEL)) && reg_be[STAT_LANE];

  // R3
  cap_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !stat_wr |=> $stable(stat[B_CAP1:B_CAP0]));

  // R3
  rsvd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr[3:2] == stat_word(CHANNEL)) |-> (reg_rdata[23] == 1'b0 && reg_rdata[20:19] == 2'b00));

  // R7
  err_set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_abort |=> stat[B_ERR]);

  // R8
  act_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(start_lvl) |=> stat[B_ACT]);

  // R8
  act_eot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (eot_done && !$rose(start_lvl)) |=> !stat[B_ACT]);

  // R9
  ptr_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    desc_base[1:0] == 2'b00);

endmodule

bind rdma_chan_regs rdma_chan_regs_chk #(.CHANNEL(CHANNEL)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .reg_addr  (reg_addr),
  .reg_wr    (reg_wr),
  .reg_be    (reg_be),
  .reg_rdata (reg_rdata),
  .start_lvl (start_lvl),
  .eot_done  (eot_done),
  .bus_abort (bus_abort),
  .desc_base (desc_base),
  .stat      (status_q)
);

// File: tb/rdma_chan_regs_bench.sv
`timescale 1ns/1ps
module rdma_chan_regs_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic        wr_p = 1'b0, wr_s = 1'b0;
  logic [3:0]  reg_be = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] rdata_p, rdata_s, base_p, base_s;
  logic        drv_irq = 1'b0, start_lvl = 1'b0, eot_done = 1'b0, bus_abort = 1'b0;
  int          applied = 0, miscompares = 0;
  bit          done = 1'b0;

  always #2.5 clk = ~clk;

  rdma_chan_regs #(.CHANNEL(0)) u_rdma_chan_regs (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(wr_p), .reg_be(reg_be),
    .reg_wdata(reg_wdata), .reg_rdata(rdata_p), .drv_irq(drv_irq), .start_lvl(start_lvl),
    .eot_done(eot_done), .bus_abort(bus_abort), .desc_base(base_p));

  rdma_chan_regs #(.CHANNEL(1)) u_rdma_chan_regs_sec (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(wr_s), .reg_be(reg_be),
    .reg_wdata(reg_wdata), .reg_rdata(rdata_s), .drv_irq(drv_irq), .start_lvl(start_lvl),
    .eot_done(eot_done), .bus_abort(bus_abort), .desc_base(base_s));

  // {addr, be, wdata, expected read of the same word}, primary copy
  localparam logic [71:0] VEC [11] = '{
    {4'h4, 4'hF, 32'h12345677, 32'h12345674},
    {4'h4, 4'h1, 32'h000000FF, 32'h123456FC},
    {4'h5, 4'h8, 32'hAB000000, 32'hAB3456FC},
    {4'h6, 4'h6, 32'h00CDEF00, 32'hABCDEFFC},
    {4'h2, 4'h4, 32'h00600000, 32'h00600000},
    {4'h2, 4'h4, 32'h00FF0000, 32'h00600000},
    {4'h3, 4'hB, 32'hFFFFFFFF, 32'h00600000},
    {4'h8, 4'hF, 32'hFFFFFFFF, 32'h00000000},
    {4'hC, 4'hF, 32'hFFFFFFFF, 32'h00000000},
    {4'h0, 4'h0, 32'h00000000, 32'h00600000},
    {4'h4, 4'h0, 32'hFFFFFFFF, 32'hABCDEFFC}
  };

  function automatic logic [31:0] sd(input logic [7:0] b);
    return {8'h00, b, 16'h0000};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    applied++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  // Called at a negedge; returns at the following negedge.
  task automatic wr(input bit sec, input logic [3:0] a, input logic [3:0] be, input logic [31:0] d);
    reg_addr = a; reg_be = be; reg_wdata = d;
    wr_p = !sec; wr_s = sec;
    @(negedge clk);
    wr_p = 1'b0; wr_s = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a);
    reg_addr = a;
    #0.5;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      miscompares++;
      applied++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", applied, miscompares);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    rd(4'h2); chk("R1 status", rdata_p, 32'h0);
    rd(4'h4); chk("R1 pointer", rdata_p, 32'h0);
    chk("R1 desc_base", base_p, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2 R3 R9 R10 table walk
    for (int i = 0; i < 11; i++) begin
      wr(1'b0, VEC[i][71:68], VEC[i][67:64], VEC[i][63:32]);
      rd(VEC[i][71:68]);
      chk($sformatf("R2/R3/R9/R10 vec%0d", i), rdata_p, VEC[i][31:0]);
      @(negedge clk);
    end
    chk("R9 desc_base", base_p, 32'hABCDEFFC);

    // R4 interrupt latency
    drv_irq = 1'b1;
    repeat (2) @(negedge clk);
    rd(4'h2); chk("R4 not yet", rdata_p, sd(8'h60));
    @(negedge clk);
    rd(4'h2); chk("R4 set", rdata_p, sd(8'h64));
    @(negedge clk);

    // R5 clear while high, no reassertion
    wr(1'b0, 4'h2, 4'h4, 32'h00640000);
    rd(4'h2); chk("R5 cleared", rdata_p, sd(8'h60));
    repeat (5) @(negedge clk);
    rd(4'h2); chk("R5 held low", rdata_p, sd(8'h60));
    drv_irq = 1'b0;
    repeat (4) @(negedge clk);
    drv_irq = 1'b1;
    repeat (3) @(negedge clk);
    rd(4'h2); chk("R5 new edge", rdata_p, sd(8'h64));
    @(negedge clk);

    // R7 writing zero keeps the flag
    wr(1'b0, 4'h2, 4'h4, 32'h00600000);
    rd(4'h2); chk("R7 zero write", rdata_p, sd(8'h64));
    @(negedge clk);
    wr(1'b0, 4'h2, 4'h4, 32'h00640000);

    // R6 error set and clear
    bus_abort = 1'b1;
    @(negedge clk);
    bus_abort = 1'b0;
    rd(4'h2); chk("R6 set", rdata_p, sd(8'h62));
    @(negedge clk);
    wr(1'b0, 4'h2, 4'h4, 32'h00620000);
    rd(4'h2); chk("R6 clear", rdata_p, sd(8'h60));
    @(negedge clk);

    // R7 set wins over clear in the same cycle
    bus_abort = 1'b1;
    wr(1'b0, 4'h2, 4'h4, 32'h00620000);
    bus_abort = 1'b0;
    rd(4'h2); chk("R7 set wins", rdata_p, sd(8'h62));
    @(negedge clk);
    wr(1'b0, 4'h2, 4'h4, 32'h00620000);

    // R8 active flag
    start_lvl = 1'b1;
    @(negedge clk);
    rd(4'h2); chk("R8 start", rdata_p, sd(8'h61));
    @(negedge clk);
    wr(1'b0, 4'h2, 4'h4, 32'h00670000);
    rd(4'h2); chk("R8 read-only", rdata_p, sd(8'h61));
    @(negedge clk);
    eot_done = 1'b1;
    @(negedge clk);
    eot_done = 1'b0;
    rd(4'h2); chk("R8 eot clear", rdata_p, sd(8'h60));
    repeat (3) @(negedge clk);
    rd(4'h2); chk("R8 level no reset", rdata_p, sd(8'h60));
    start_lvl = 1'b0;
    @(negedge clk);
    start_lvl = 1'b1; eot_done = 1'b1;
    @(negedge clk);
    eot_done = 1'b0;
    rd(4'h2); chk("R8 start wins", rdata_p, sd(8'h61));
    @(negedge clk);
    start_lvl = 1'b0;
    @(negedge clk);
    rd(4'h2); chk("R8 stop clear", rdata_p, sd(8'h60));
    @(negedge clk);

    // R2 secondary copy decode
    rd(4'h8); chk("R2 sec status", rdata_s, sd(8'h06));
    rd(4'h0); chk("R2 sec offset 0", rdata_s, 32'h0);
    @(negedge clk);
    wr(1'b1, 4'hA, 4'h4, 32'h00660000);
    rd(4'h8); chk("R2 sec status wr", rdata_s, sd(8'h60));
    @(negedge clk);
    wr(1'b1, 4'hC, 4'hF, 32'hDEADBEEF);
    rd(4'hC); chk("R2 sec pointer", rdata_s, 32'hDEADBEEC);
    rd(4'h4); chk("R2 sec offset 4", rdata_s, 32'h0);
    chk("R9 sec desc_base", base_s, 32'hDEADBEEC);
    chk("R2 primary untouched", base_p, 32'hABCDEFFC);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", applied, miscompares);
    $finish;
  end

endmodule